// File: doc/BRIEF.md
# Condition Register Logic Stage

A combinational execution stage for a 32-bit condition register. The register holds eight 4-bit fields. The stage receives a 64-bit operand, the current condition register, the 32-bit instruction word, a 3-bit operation code and an opaque context word. It returns a 64-bit result, the updated condition register, and the context word unchanged. It decodes only the instruction fields it needs.

Three operations are handled:
- Move-to-fields writes operand nibbles into the condition register under an 8-bit field mask.
- Move-from copies the register into the result, either whole or as the masked fields only.
- Bit-logic combines two register bits through a 4-bit truth table carried in the instruction, and writes the outcome to a third bit.

Register bits are numbered big-endian, so bit number n sits at vector position 31-n.

Top module: `cr_logic_stage`

## Requirements
- R1: `ctx_o` equals `ctx_i` for every operation code.
- R2: Move-to-fields is operation code 1. The field mask bit i is `insn_i[12+i]`. When bit i is set, `cr_o[4i+3:4i]` equals `opnd_i[4i+3:4i]`.
- R3: Under move-to-fields, every field whose mask bit is clear keeps its `cr_i` value, and `res_o` is zero.
- R4: Move-from is operation code 2. When `insn_i[20]` is 0, `res_o` equals `cr_i` zero-extended to 64 bits. Under move-from, `cr_o` always equals `cr_i`.
- R5: Under move-from with `insn_i[20]` = 1, result field i equals `cr_i` field i when mask bit `insn_i[12+i]` is set, and is zero otherwise. `res_o[63:32]` is zero.
- R6: Bit-logic is operation code 3. The target bit index is `insn_i[25:21]`, the first source index is `insn_i[20:16]` and the second source index is `insn_i[15:11]`. Bit number n maps to vector position 31-n.
- R7: The bit-logic output equals `insn_i[6 + 2*a + b]`, where a and b are the two source bits. The following table values give these functions:
  - 1000 gives AND
  - 0100 gives a AND NOT b
  - 1001 gives XNOR
  - 0111 gives NAND
  - 0001 gives NOR
  - 1110 gives OR
  - 1101 gives a OR NOT b
  - 0110 gives XOR
- R8: Bit-logic changes no `cr_o` bit other than the target bit, and drives `res_o` to zero.
- R9: For operation codes 0 and 4 to 7, `cr_o` equals `cr_i` and `res_o` is zero.
- R10: The stage has no state. Every output settles from the present inputs alone, with no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 3 | Operation code: 1 move-to-fields, 2 move-from, 3 bit-logic |
| insn_i | input | 32 | Instruction word carrying mask, selector, indices and truth table |
| opnd_i | input | 64 | Source operand for move-to-fields |
| cr_i | input | 32 | Current condition register |
| ctx_i | input | 16 | Opaque operation context |
| res_o | output | 64 | Result value |
| cr_o | output | 32 | Updated condition register |
| ctx_o | output | 16 | Context passed through |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between any input and any output. The bench changes inputs on the falling edge of its own pacing clock. It samples all three outputs one nanosecond later, well before the next rising edge, so every comparison sees settled combinational values. Expected values come from bench functions that implement the field, index and truth-table rules directly.

// File: rtl/cr_stage_pkg.sv
package cr_stage_pkg;
  typedef enum logic [2:0] {
    CR_OP_NONE      = 3'd0,
    CR_OP_MOVE_TO   = 3'd1,
    CR_OP_MOVE_FROM = 3'd2,
    CR_OP_BIT_LOGIC = 3'd3
  } cr_op_e;

  localparam int unsigned MASK_LSB = 12;
  localparam int unsigned SEL_BIT  = 20;
  localparam int unsigned DST_LSB  = 21;
  localparam int unsigned SRCA_LSB = 16;
  localparam int unsigned SRCB_LSB = 11;
  localparam int unsigned TT_LSB   = 6;
  localparam int unsigned TT_W     = 4;
endpackage

// File: rtl/cr_field_move.sv
module cr_field_move #(
  parameter int unsigned NF = 8,
  parameter int unsigned FW = 4,
  localparam int unsigned CW = NF * FW
) (
  input  logic [CW-1:0] src_i,
  input  logic [CW-1:0] cr_i,
  input  logic [NF-1:0] mask_i,
  output logic [CW-1:0] cr_o
);
  for (genvar i = 0; i < NF; i++) begin : g_fld
    assign cr_o[i*FW +: FW] = mask_i[i] ? src_i[i*FW +: FW] : cr_i[i*FW +: FW];
  end
endmodule

// File: rtl/cr_read_unit.sv
module cr_read_unit #(
  parameter int unsigned NF    = 8,
  parameter int unsigned FW    = 4,
  parameter int unsigned RES_W = 64,
  localparam int unsigned CW   = NF * FW
) (
  input  logic [CW-1:0]    cr_i,
  input  logic [NF-1:0]    mask_i,
  input  logic             whole_i,
  output logic [RES_W-1:0] res_o
);
  logic [CW-1:0] fld;

  for (genvar i = 0; i < NF; i++) begin : g_fld
    assign fld[i*FW +: FW] = (whole_i || mask_i[i]) ? cr_i[i*FW +: FW] : '0;
  end

  assign res_o = RES_W'(fld);
endmodule

// File: rtl/cr_bit_logic.sv
module cr_bit_logic #(
  parameter int unsigned CW   = 32,
  parameter int unsigned TT_W = 4,
  localparam int unsigned IW  = $clog2(CW)
) (
  input  logic [CW-1:0]   cr_i,
  input  logic [IW-1:0]   dst_i,
  input  logic [IW-1:0]   srca_i,
  input  logic [IW-1:0]   srcb_i,
  input  logic [TT_W-1:0] tt_i,
  output logic [CW-1:0]   cr_o
);
  logic [IW-1:0] dst_pos, a_pos, b_pos;
  logic          bit_a, bit_b, bit_r;

  // big-endian numbering: bit n lives at position CW-1-n
  assign dst_pos = IW'(CW - 1) - dst_i;
  assign a_pos   = IW'(CW - 1) - srca_i;
  assign b_pos   = IW'(CW - 1) - srcb_i;
  assign bit_a   = cr_i[a_pos];
  assign bit_b   = cr_i[b_pos];
  assign bit_r   = tt_i[{bit_a, bit_b}];

  always_comb begin
    cr_o          = cr_i;
    cr_o[dst_pos] = bit_r;
  end
endmodule

// File: rtl/cr_logic_stage.sv
module cr_logic_stage
  import cr_stage_pkg::*;
#(
  parameter int unsigned OPND_W    = 64,
  parameter int unsigned CR_FIELDS = 8,
  parameter int unsigned FIELD_W   = 4,
  parameter int unsigned INSN_W    = 32,
  parameter int unsigned CTX_W     = 16,
  localparam int unsigned CR_W     = CR_FIELDS * FIELD_W,
  localparam int unsigned IDX_W    = $clog2(CR_W)
) (
  input  logic [2:0]        op_i,
  input  logic [INSN_W-1:0] insn_i,
  input  logic [OPND_W-1:0] opnd_i,
  input  logic [CR_W-1:0]   cr_i,
  input  logic [CTX_W-1:0]  ctx_i,
  output logic [OPND_W-1:0] res_o,
  output logic [CR_W-1:0]   cr_o,
  output logic [CTX_W-1:0]  ctx_o
);
  logic [CR_FIELDS-1:0] mask;
  logic                 masked_sel;
  logic [CR_W-1:0]      cr_mv, cr_bl;
  logic [OPND_W-1:0]    res_rd;
  logic                 is_mv, is_rd, is_bl;

  assign mask       = insn_i[MASK_LSB +: CR_FIELDS];
  assign masked_sel = insn_i[SEL_BIT];
  assign is_mv      = (op_i == CR_OP_MOVE_TO);
  assign is_rd      = (op_i == CR_OP_MOVE_FROM);
  assign is_bl      = (op_i == CR_OP_BIT_LOGIC);

  cr_field_move #(.NF(CR_FIELDS), .FW(FIELD_W)) u_move (
    .src_i  (opnd_i[CR_W-1:0]),
    .cr_i   (cr_i),
    .mask_i (mask),
    .cr_o   (cr_mv)
  );

  cr_read_unit #(.NF(CR_FIELDS), .FW(FIELD_W), .RES_W(OPND_W)) u_read (
    .cr_i    (cr_i),
    .mask_i  (mask),
    .whole_i (~masked_sel),
    .res_o   (res_rd)
  );

  cr_bit_logic #(.CW(CR_W), .TT_W(TT_W)) u_bits (
    .cr_i   (cr_i),
    .dst_i  (insn_i[DST_LSB +: IDX_W]),
    .srca_i (insn_i[SRCA_LSB +: IDX_W]),
    .srcb_i (insn_i[SRCB_LSB +: IDX_W]),
    .tt_i   (insn_i[TT_LSB +: TT_W]),
    .cr_o   (cr_bl)
  );

  always_comb begin
    res_o = '0;
    cr_o  = cr_i;
    unique case (1'b1)
      is_mv:   cr_o  = cr_mv;
      is_rd:   res_o = res_rd;
      is_bl:   cr_o  = cr_bl;
      default: ;
    endcase
  end

  assign ctx_o = ctx_i;

  always_comb begin
    if (!is_mv && !is_rd && !is_bl) begin
      a_r9_idle: assert (res_o == '0 && cr_o == cr_i) else $error("R9 idle op altered outputs");
    end
    if (is_rd) begin
      a_r4_cr_hold: assert (cr_o == cr_i) else $error("R4 move-from altered cr");
    end
    if (is_bl) begin
      a_r8_one_bit: assert ($countones(cr_o ^ cr_i) <= 1 && res_o == '0)
        else $error("R8 bit-logic touched more than target");
    end
  end

  for (genvar i = 0; i < CR_FIELDS; i++) begin : g_chk
    always_comb begin
      if (is_mv && !mask[i]) begin
        a_r3_keep: assert (cr_o[i*FIELD_W +: FIELD_W] == cr_i[i*FIELD_W +: FIELD_W])
          else $error("R3 unmasked field changed");
      end
      if (is_rd && masked_sel && !mask[i]) begin
        a_r5_zero: assert (res_o[i*FIELD_W +: FIELD_W] == '0)
          else $error("R5 unselected field not zero");
      end
    end
  end
endmodule

// File: tb/cr_logic_stage_tb.sv
`timescale 1ns/1ps
module cr_logic_stage_tb;
  logic        clk = 1'b0;
  logic [2:0]  op;
  logic [31:0] insn;
  logic [63:0] opnd;
  logic [31:0] cr;
  logic [15:0] ctx;
  logic [63:0] res;
  logic [31:0] cr_out;
  logic [15:0] ctx_out;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  cr_logic_stage u_dut (
    .op_i(op), .insn_i(insn), .opnd_i(opnd), .cr_i(cr), .ctx_i(ctx),
    .res_o(res), .cr_o(cr_out), .ctx_o(ctx_out)
  );

  function automatic logic [31:0] exp_cr(logic [2:0] o, logic [31:0] w, logic [63:0] d, logic [31:0] c);
    logic [31:0] r = c;
    if (o == 3'd1) begin
      for (int i = 0; i < 8; i++) if (w[12+i]) r[4*i +: 4] = d[4*i +: 4];
    end else if (o == 3'd3) begin
      logic a, b;
      a = c[31 - w[20:16]];
      b = c[31 - w[15:11]];
      r[31 - w[25:21]] = w[6 + 2*a + b];
    end
    return r;
  endfunction

  function automatic logic [63:0] exp_res(logic [2:0] o, logic [31:0] w, logic [31:0] c);
    logic [63:0] r = '0;
    if (o == 3'd2) begin
      if (!w[20]) r = {32'b0, c};
      else for (int i = 0; i < 8; i++) if (w[12+i]) r[4*i +: 4] = c[4*i +: 4];
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [2:0] o, logic [31:0] w, logic [63:0] d, logic [31:0] c, logic [15:0] x, string tag);
    @(negedge clk);
    op = o; insn = w; opnd = d; cr = c; ctx = x;
    #1;
    chk({tag, " R1 ctx"}, 64'(ctx_out), 64'(x));
    chk({tag, " cr"}, 64'(cr_out), 64'(exp_cr(o, w, d, c)));
    chk({tag, " res"}, res, exp_res(o, w, c));
  endtask

  function automatic logic [31:0] bl_insn(int bt, int ba, int bb, logic [3:0] tt);
    logic [31:0] w = '0;
    w[25:21] = 5'(bt); w[20:16] = 5'(ba); w[15:11] = 5'(bb); w[9:6] = tt;
    return w;
  endfunction

  initial begin
    logic [3:0] tabs [8] = '{4'b1000, 4'b0100, 4'b1001, 4'b0111, 4'b0001, 4'b1110, 4'b1101, 4'b0110};
    void'($urandom(32'h5eed));
    // R10: settled outputs from all-zero inputs
    apply(3'd0, '0, '0, '0, '0, "R10 zero");
    chk("R10 zero res", res, 64'd0);
    // R2 R3 full and empty masks
    apply(3'd1, 32'h000F_F000, 64'hDEAD_BEEF_1234_5678, 32'hA5A5_A5A5, 16'h1111, "R2 full mask");
    chk("R2 full mask cr", 64'(cr_out), 64'h1234_5678);
    apply(3'd1, 32'h0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 32'h0F0F_0F0F, 16'h2222, "R3 empty mask");
    chk("R3 empty mask cr", 64'(cr_out), 64'h0F0F_0F0F);
    apply(3'd1, 32'h0000_5000, 64'h0000_0000_FFFF_FFFF, 32'h0, 16'h3, "R2 mask 05");
    chk("R2 mask 05 cr", 64'(cr_out), 64'h0000_0F0F);
    // R4 R5
    apply(3'd2, 32'h000F_F000, '0, 32'h89AB_CDEF, 16'h4, "R4 whole");
    chk("R4 whole res", res, 64'h0000_0000_89AB_CDEF);
    apply(3'd2, 32'h0018_1000, '0, 32'h89AB_CDEF, 16'h5, "R5 mask 81");
    chk("R5 mask 81 res", res, 64'h0000_0000_8000_000F);
    apply(3'd2, 32'h0010_0000, '0, 32'hFFFF_FFFF, 16'h6, "R5 mask none");
    chk("R5 mask none res", res, 64'd0);
    // R6 index ends: bit 0 is position 31, bit 31 is position 0
    apply(3'd3, bl_insn(0, 31, 31, 4'b1000), '0, 32'h0000_0001, 16'h7, "R6 ends");
    chk("R6 ends cr", 64'(cr_out), 64'h8000_0001);
    apply(3'd3, bl_insn(5, 5, 5, 4'b0001), '0, 32'h0400_0000, 16'h8, "R6 same idx");
    chk("R6 same idx cr", 64'(cr_out), 64'h0000_0000);
    // R7 named functions, all source combinations
    for (int t = 0; t < 8; t++) begin
      for (int ab = 0; ab < 4; ab++) begin
        logic a = ab[1], b = ab[0], f;
        logic [31:0] c = '0;
        c[31-3] = a; c[31-17] = b;
        case (t)
          0: f = a & b;      1: f = a & ~b;   2: f = ~(a ^ b); 3: f = ~(a & b);
          4: f = ~(a | b);   5: f = a | b;    6: f = a | ~b;   default: f = a ^ b;
        endcase
        apply(3'd3, bl_insn(9, 3, 17, tabs[t]), '0, c, 16'(t), "R7 table");
        chk("R7 func bit", 64'(cr_out[31-9]), 64'(f));
        chk("R8 res zero", res, 64'd0);
      end
    end
    // R9 unhandled codes
    for (int o = 4; o < 8; o++) begin
      apply(3'(o), 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 32'h1357_9BDF, 16'hABCD, "R9 unhandled");
      chk("R9 cr hold", 64'(cr_out), 64'h1357_9BDF);
    end
    // random mix across all codes
    for (int n = 0; n < 3000; n++) begin
      apply(3'($urandom_range(0, 7)), $urandom, {$urandom, $urandom}, $urandom, 16'($urandom), "R2 R4 R5 R8 random");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule